// File: doc/BRIEF.md
# Cascadable LCD Column Driver Core

This block is the digital heart of an 80-column dot-matrix LCD column driver. Display data arrives four bits at a time. Each accepted group enters an internal shift register on the falling edge of a shift strobe. A runtime direction input picks whether the line fills from the left end or from the right end. When a load strobe falls, the whole line is copied into a line latch.

Every column then carries a 2-bit drive-level select code. The code is formed from the latched bit, a frame-polarity (alternating) input and an active-low blanking input. The analog stage outside this block turns each code into a bias voltage.

Several drivers can share one data stream by chaining them. Each driver holds a disable flip-flop. Once it has taken its 20 groups, it stops listening and pulls its cascade output low, which enables the next driver. The two cascade pins trade their input and output roles with the shift direction. All strobes are sampled on the core clock `clk`, and a falling edge is detected as high on one clock followed by low on the next.

Top module: `lcdcol_driver`

## Requirements
- R1: When a falling edge of `shift_clk` is detected while the driver is enabled (selected enable input low and fewer than 20 groups taken), the 4 bits on `grp_i` are captured into the shift register in that same `clk` cycle.
- R2: With `shift_rtl`=0, after 20 accepted groups and a load, group g (counting from 0) lands on columns 4g+1..4g+4. `grp_i[0]` goes to the lowest-numbered column of the group. Column c (1..80) is reported on `level_o[2c-1:2c-2]`.
- R3: With `shift_rtl`=1, the first accepted group lands on columns 77..80, and group g lands on columns 77-4g..80-4g, with `grp_i[0]` again on the lowest-numbered column.
- R4: While the selected enable input is high, shift strobes change neither the line content nor the group count.
- R5: With `shift_rtl`=0, `cas_left_i` is the enable input and the right pin drives (`cas_right_oe`=1, `cas_left_oe`=0). With `shift_rtl`=1, `cas_right_i` is the enable input and the left pin drives. The driven cascade value is high until 20 groups have been taken.
- R6: The 20th accepted group sets the disable flip-flop. The cascade output goes low, and later shift strobes are ignored until the next load. After 19 groups the cascade output is still high.
- R7: A detected falling edge of `load_clk` copies the shift register into the line latch, clears the group count and clears the disable flip-flop, so the cascade output returns high.
- R8: With `blank_n`=1, each column code is 01 for alt=0/bit=0, 00 for alt=0/bit=1, 10 for alt=1/bit=0 and 11 for alt=1/bit=1.
- R9: With `blank_n`=0, every column code is 00 at once, whatever the data and `alt` are.
- R10: While `rst_n` is low, the shift register, the latch and the disable flip-flop are cleared and the cascade output is high. After reset, with alt=0 and `blank_n`=1, every column reads 01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock that samples the strobes |
| rst_n | input | 1 | Asynchronous active-low reset |
| shift_clk | input | 1 | Data shift strobe, acts on its falling edge |
| load_clk | input | 1 | Line latch strobe, acts on its falling edge |
| grp_i | input | 4 | Parallel data group, bit 0 goes to the lowest column |
| shift_rtl | input | 1 | 1 = fill from the right end, 0 = fill from the left end |
| alt | input | 1 | Frame polarity |
| blank_n | input | 1 | Low forces every column to code 00 |
| cas_left_i | input | 1 | Left cascade pin input value |
| cas_left_o | output | 1 | Left cascade pin output value |
| cas_left_oe | output | 1 | Left cascade pin drive enable |
| cas_right_i | input | 1 | Right cascade pin input value |
| cas_right_o | output | 1 | Right cascade pin output value |
| cas_right_oe | output | 1 | Right cascade pin drive enable |
| level_o | output | 160 | Per-column 2-bit level select codes |

## Verification
On every cycle, the assertions check four things. The group count stays in range. A disabled or full driver leaves its shift register untouched. A load clears the count and the disable flip-flop, and the latch moves only on a load. Blanking forces all codes to 00. Only the bench's scenarios can show where each group ends up in both directions, the routing of the enable input to the correct pin, and the exact count at which the cascade output falls. They also show the code table under each combination of data, polarity and blanking.

// File: rtl/lcdcol_pkg.sv
package lcdcol_pkg;
   typedef enum logic [1:0] {
      LVL_SEL_LO  = 2'b00,
      LVL_IDLE_LO = 2'b01,
      LVL_IDLE_HI = 2'b10,
      LVL_SEL_HI  = 2'b11
   } lvl_e;
endpackage

// File: rtl/lcdcol_fall.sv
module lcdcol_fall #(
   parameter int W = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] sig_i,
   output logic [W-1:0] fall_o
);
   if (W < 1) begin : g_chk
      $error("lcdcol_fall: W must be at least 1");
   end

   logic [W-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= sig_i;
   end

   for (genvar i = 0; i < W; i++) begin : g_bit
      assign fall_o[i] = prev_q[i] & ~sig_i[i];
   end
endmodule

// File: rtl/lcdcol_shift.sv
module lcdcol_shift #(
   parameter int COLS = 80,
   parameter int GRP  = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            shift_ev,
   input  logic            load_ev,
   input  logic            rtl,
   input  logic            en_in_n,
   input  logic [GRP-1:0]  grp_i,
   output logic [COLS-1:0] line_o,
   output logic            done_o
);
   localparam int GROUPS = COLS / GRP;
   localparam int CNT_W  = (GROUPS > 1) ? $clog2(GROUPS) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(GROUPS - 1);

   if (COLS % GRP != 0) begin : g_chk_div
      $error("lcdcol_shift: COLS must be a multiple of GRP");
   end
   if (GRP >= COLS) begin : g_chk_size
      $error("lcdcol_shift: GRP must be smaller than COLS");
   end

   logic [COLS-1:0]  sreg_q;
   logic [COLS-1:0]  line_q;
   logic [CNT_W-1:0] cnt_q;
   logic             done_q;
   logic             accept;
   logic [COLS-1:0]  sreg_nxt;

   assign accept = shift_ev & ~en_in_n & ~done_q;

   always_comb begin
      if (rtl) sreg_nxt = {sreg_q[COLS-GRP-1:0], grp_i};
      else     sreg_nxt = {grp_i, sreg_q[COLS-1:GRP]};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sreg_q <= '0;
         line_q <= '0;
         cnt_q  <= '0;
         done_q <= 1'b0;
      end else if (load_ev) begin
         line_q <= sreg_q;
         cnt_q  <= '0;
         done_q <= 1'b0;
      end else if (accept) begin
         sreg_q <= sreg_nxt;
         if (cnt_q == LAST) done_q <= 1'b1;
         else               cnt_q  <= cnt_q + CNT_W'(1);
      end
   end

   assign line_o = line_q;
   assign done_o = done_q;

   AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LAST);  // R6
   AST_IGNORE_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
      (en_in_n && !load_ev) |=> $stable(sreg_q) && $stable(cnt_q));  // R4
   AST_IGNORE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      (done_q && !load_ev) |=> $stable(sreg_q));  // R6
   AST_LOAD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      load_ev |=> (!done_q && cnt_q == '0));  // R7
   AST_LINE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !load_ev |=> $stable(line_q));  // R7
endmodule

// File: rtl/lcdcol_level.sv
module lcdcol_level
   import lcdcol_pkg::*;
#(
   parameter int COLS = 80
) (
   input  logic [COLS-1:0]   line_i,
   input  logic              alt_i,
   input  logic              blank_n_i,
   output logic [2*COLS-1:0] level_o
);
   if (COLS < 1) begin : g_chk
      $error("lcdcol_level: COLS must be at least 1");
   end

   for (genvar c = 0; c < COLS; c++) begin : g_col
      lvl_e code;
      always_comb begin
         if (!blank_n_i)  code = LVL_SEL_LO;
         else begin
            unique case ({alt_i, line_i[c]})
               2'b00:   code = LVL_IDLE_LO;
               2'b01:   code = LVL_SEL_LO;
               2'b10:   code = LVL_IDLE_HI;
               default: code = LVL_SEL_HI;
            endcase
         end
      end
      assign level_o[2*c +: 2] = code;
   end
endmodule

// File: rtl/lcdcol_driver.sv
module lcdcol_driver #(
   parameter int COLS = 80,
   parameter int GRP  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              shift_clk,
   input  logic              load_clk,
   input  logic [GRP-1:0]    grp_i,
   input  logic              shift_rtl,
   input  logic              alt,
   input  logic              blank_n,
   input  logic              cas_left_i,
   output logic              cas_left_o,
   output logic              cas_left_oe,
   input  logic              cas_right_i,
   output logic              cas_right_o,
   output logic              cas_right_oe,
   output logic [2*COLS-1:0] level_o
);
   logic [1:0]      fall;
   logic [COLS-1:0] line;
   logic            done;
   logic            en_in_n;
   logic            casc_val;

   lcdcol_fall #(.W(2)) u_fall (
      .clk    (clk),
      .rst_n  (rst_n),
      .sig_i  ({load_clk, shift_clk}),
      .fall_o (fall)
   );

   assign en_in_n = shift_rtl ? cas_right_i : cas_left_i;

   lcdcol_shift #(.COLS(COLS), .GRP(GRP)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_ev (fall[0]),
      .load_ev  (fall[1]),
      .rtl      (shift_rtl),
      .en_in_n  (en_in_n),
      .grp_i    (grp_i),
      .line_o   (line),
      .done_o   (done)
   );

   lcdcol_level #(.COLS(COLS)) u_level (
      .line_i    (line),
      .alt_i     (alt),
      .blank_n_i (blank_n),
      .level_o   (level_o)
   );

   assign casc_val     = ~done;
   assign cas_left_o   = casc_val;
   assign cas_right_o  = casc_val;
   assign cas_left_oe  = shift_rtl;
   assign cas_right_oe = ~shift_rtl;

   AST_BLANK_ALL_LO: assert property (@(posedge clk) disable iff (!rst_n)
      !blank_n |-> (level_o == '0));  // R9
   AST_CASC_REARM: assert property (@(posedge clk) disable iff (!rst_n)
      fall[1] |=> (cas_left_o && cas_right_o));  // R7
endmodule

// File: tb/lcdcol_driver_bench.sv
`timescale 1ns/1ps
module lcdcol_driver_bench;
   localparam int COLS = 80;
   localparam int GRP  = 4;
   localparam int NGRP = COLS / GRP;
   localparam int LW   = 2 * COLS;

   // {fill bit, alt, blank_n, expected code}
   localparam logic [4:0] VEC [8] = '{
      5'b0_0_1_01, 5'b1_0_1_00, 5'b0_1_1_10, 5'b1_1_1_11,
      5'b0_0_0_00, 5'b1_1_0_00, 5'b1_0_0_00, 5'b0_1_0_00
   };

   logic clk = 0;
   logic rst_n = 0;
   logic shift_clk = 0, load_clk = 0;
   logic [GRP-1:0] grp_i = '0;
   logic shift_rtl = 0, alt = 0, blank_n = 1;
   logic cas_left_i = 0, cas_right_i = 1;
   logic cas_left_o, cas_left_oe, cas_right_o, cas_right_oe;
   logic [LW-1:0] level_o;

   int errors = 0;
   int checks = 0;

   always #2.5 clk = ~clk;

   lcdcol_driver #(.COLS(COLS), .GRP(GRP)) u_lcdcol_driver (
      .clk(clk), .rst_n(rst_n), .shift_clk(shift_clk), .load_clk(load_clk),
      .grp_i(grp_i), .shift_rtl(shift_rtl), .alt(alt), .blank_n(blank_n),
      .cas_left_i(cas_left_i), .cas_left_o(cas_left_o), .cas_left_oe(cas_left_oe),
      .cas_right_i(cas_right_i), .cas_right_o(cas_right_o),
      .cas_right_oe(cas_right_oe), .level_o(level_o)
   );

   task automatic chk(input string req, input logic [LW-1:0] act, input logic [LW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic send(input logic [GRP-1:0] d);
      @(negedge clk); grp_i = d; shift_clk = 1;
      @(negedge clk); shift_clk = 0;
      @(negedge clk);
   endtask

   task automatic load();
      @(negedge clk); load_clk = 1;
      @(negedge clk); load_clk = 0;
      @(negedge clk);
   endtask

   function automatic logic [GRP-1:0] pat(input int g);
      return GRP'((g * 7 + 3) % 16);
   endfunction

   function automatic logic [LW-1:0] codes_of(input logic [COLS-1:0] bits, input logic a, input logic b);
      logic [LW-1:0] r;
      for (int c = 0; c < COLS; c++) begin
         if (!b)                r[2*c +: 2] = 2'b00;
         else if (!a && !bits[c]) r[2*c +: 2] = 2'b01;
         else if (!a)           r[2*c +: 2] = 2'b00;
         else if (!bits[c])     r[2*c +: 2] = 2'b10;
         else                   r[2*c +: 2] = 2'b11;
      end
      return r;
   endfunction

   initial begin
      #(200000 * 5);
      errors++; checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [COLS-1:0] ebits;
      repeat (3) @(negedge clk);
      // R10: reset state
      chk("R10 levels after reset", level_o, codes_of('0, 1'b0, 1'b1));
      chk("R10 cascade high in reset", LW'({cas_left_o, cas_right_o}), LW'(2'b11));
      rst_n = 1;
      @(negedge clk);
      load();

      // R8 R9: table of codes
      for (int v = 0; v < 8; v++) begin
         shift_rtl = 0; cas_left_i = 0; cas_right_i = 1;
         alt = 0; blank_n = 1;
         for (int g = 0; g < NGRP; g++) send({GRP{VEC[v][4]}});
         load();
         alt = VEC[v][3]; blank_n = VEC[v][2];
         #1;
         chk($sformatf("R8/R9 vector %0d", v), level_o, {COLS{VEC[v][1:0]}});
      end
      alt = 0; blank_n = 1;

      // R2 R5: left-to-right mapping, left pin is the enable input
      shift_rtl = 0; cas_left_i = 0; cas_right_i = 1;
      #1;
      chk("R5 pin roles ltr", LW'({cas_left_oe, cas_right_oe}), LW'(2'b01));
      for (int g = 0; g < NGRP; g++) begin
         send(pat(g));
         if (g == NGRP - 2) chk("R6 cascade high after 19", LW'(cas_right_o), LW'(1));
      end
      chk("R6 cascade low after 20", LW'(cas_right_o), LW'(0));
      send(4'hF); // R6: ignored when full
      load();
      for (int i = 0; i < COLS; i++) ebits[i] = pat(i / GRP)[i % GRP];
      chk("R2 R1 R6 ltr mapping", level_o, codes_of(ebits, 1'b0, 1'b1));
      chk("R7 cascade rearmed", LW'(cas_right_o), LW'(1));

      // R3 R5: right-to-left mapping, right pin is the enable input
      shift_rtl = 1; cas_left_i = 1; cas_right_i = 0;
      #1;
      chk("R5 pin roles rtl", LW'({cas_left_oe, cas_right_oe}), LW'(2'b10));
      for (int g = 0; g < NGRP; g++) send(pat(g + 5));
      chk("R5 rtl left pin low after 20", LW'(cas_left_o), LW'(0));
      load();
      for (int i = 0; i < COLS; i++) ebits[i] = pat((COLS - 1 - i) / GRP + 5)[i % GRP];
      chk("R3 rtl mapping", level_o, codes_of(ebits, 1'b0, 1'b1));

      // R4: disabled input ignores data
      shift_rtl = 0; cas_left_i = 1; cas_right_i = 0;
      for (int g = 0; g < NGRP; g++) send(4'hA);
      chk("R4 cascade stays high", LW'(cas_right_o), LW'(1));
      load();
      chk("R4 line unchanged", level_o, codes_of(ebits, 1'b0, 1'b1));

      // R9: blanking acts immediately
      blank_n = 0; #1;
      chk("R9 blank immediate", level_o, '0);
      blank_n = 1;

      // R10: reset mid-line clears state
      cas_left_i = 0;
      send(4'hF);
      rst_n = 0; #1;
      chk("R10 reset clears", level_o, codes_of('0, 1'b0, 1'b1));
      chk("R10 reset cascade high", LW'(cas_right_o), LW'(1));

      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule